// File: doc/BRIEF.md
# PIO Timing Count Calculator

This block turns the nanosecond timing of one drive's programmed-I/O transfer into controller clock counts and packs them into the two configuration bytes the disk controller uses for that drive. A start pulse captures the total cycle time, the strobe-active time, the address setup time, the clock period, the channel flag, the drive index, the pair drive's stored setup count and the current setup-register byte. A done pulse then presents the packed read/write timing byte, the merged setup byte ready to write back, both register indices, and this drive's own unmerged setup count for the caller to store.

Each nanosecond value is divided by the clock period with a subtract loop that rounds up. Recovery is the cycle count less the active count. Any recovery above sixteen clocks is folded into the active phase. The results then go into the controller's non-linear field codes. On the secondary channel one setup register is shared by both drives, so the slower of the two setup counts is written there. The channel's pending-interrupt flag is cleared in the byte written back, so that the write does not acknowledge the interrupt.

Top module: `pio_count_calc`

## Requirements
- R1: Each of the three times becomes ceil(time / period) clocks, using 30 ns whenever the period input is 0. A time of 0 gives 0 clocks.
- R2: The recovery count is the cycle count minus the active count, or 0 when the active count is not smaller than the cycle count.
- R3: When the recovery count exceeds 16, the excess is added to the active count and recovery becomes 16.
- R4: After the R3 step the active count is limited to 16. Its low 4 bits go in rw_byte[7:4], so an active count of 16 is written as 0.
- R5: rw_byte[3:0] holds the recovery code: counts 0 and 1 give 15, counts 2 to 15 give count-1, and 16 gives 0.
- R6: The setup count is limited to 5 and coded into setup_byte[7:6]: counts 0 to 2 give 1, 3 gives 2, 4 gives 0 and 5 gives 3.
- R7: own_setup is this drive's limited setup count. On the secondary channel (sec_chan=1) the coded count is the larger of own_setup and pair_setup (itself limited to 5). On the primary channel pair_setup has no effect.
- R8: setup_byte[5:0] copies cur_setup[5:0], except that bit 2 (the channel-1 interrupt flag) is forced to 0 when sec_chan=1.
- R9: rw_idx = {sec_chan, drive_sel}. setup_idx is 2 on the secondary channel and {0, drive_sel} on the primary channel.
- R10: done is high for exactly one cycle per accepted start. busy is high from the edge that accepts start until done. A start while busy is ignored, and the outputs hold until the next done.
- R11: After reset, done, busy and every data output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, captures all inputs |
| cyc_ns | input | 16 | Total transfer cycle time, ns |
| act_ns | input | 16 | Strobe-active time, ns |
| setup_ns | input | 16 | Address setup time, ns |
| period_ns | input | 8 | Clock period, ns (0 selects 30) |
| sec_chan | input | 1 | 1 = secondary (shared setup) channel |
| drive_sel | input | 1 | Drive index on the channel |
| pair_setup | input | 3 | Stored setup count of the other drive |
| cur_setup | input | 8 | Current setup-register byte |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle result-valid pulse |
| rw_byte | output | 8 | Packed active/recovery byte |
| setup_byte | output | 8 | Setup byte to write back |
| rw_idx | output | 2 | Read/write timing register index |
| setup_idx | output | 2 | Setup register index |
| own_setup | output | 3 | Unmerged setup count to store |

## Verification
On the secondary channel, the setup merge with the pair drive and the clearing of the interrupt flag both shape setup_byte in the same packing cycle. The bench sweeps pair counts above and below the drive's own count while cur_setup carries the flag set, and on alternate runs clear. It checks that the upper two bits follow the maximum while bit 2 is cleared and the other low bits stay untouched. The same sweep crosses the recovery fold with the active limit, where both adjust the active count in one pass. Expected bytes are rebuilt from integer ceiling arithmetic.

// File: rtl/pio_calc_pkg.sv
package pio_calc_pkg;
  localparam int unsigned REC_CAP = 16;
  localparam int unsigned SET_CAP = 5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CYC, ST_ACT, ST_SET, ST_PACK
  } calc_state_t;

  // recovery clocks 0..16 -> controller nibble
  function automatic logic [3:0] enc_recovery(input logic [4:0] r);
    if (r <= 5'd1)       return 4'd15;
    else if (r >= 5'd16) return 4'd0;
    else                 return 4'(r - 5'd1);
  endfunction

  // setup clocks 0..5 -> 2-bit field for bits 7:6
  function automatic logic [1:0] enc_setup(input logic [2:0] s);
    case (s)
      3'd0, 3'd1, 3'd2: return 2'd1;
      3'd3:             return 2'd2;
      3'd4:             return 2'd0;
      default:          return 2'd3;
    endcase
  endfunction

  function automatic logic [2:0] lim_setup(input logic [15:0] s);
    return (s > 16'(SET_CAP)) ? 3'(SET_CAP) : s[2:0];
  endfunction
endpackage

// File: rtl/pio_ceil_div.sv
module pio_ceil_div #(
  parameter int TW = 16,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [TW-1:0] num,
  input  logic [PW-1:0] per,
  output logic          fin,
  output logic [TW-1:0] quo
);
  logic [TW-1:0] rem;
  logic [TW-1:0] cnt;
  logic          run;
  logic [TW-1:0] per_w;

  assign per_w = TW'(per);
  assign fin   = run && (rem == '0);
  assign quo   = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem <= '0;
      cnt <= '0;
      run <= 1'b0;
    end else if (go) begin
      rem <= num;
      cnt <= '0;
      run <= 1'b1;
    end else if (run) begin
      if (rem == '0) begin
        run <= 1'b0;
      end else begin
        rem <= (rem > per_w) ? rem - per_w : '0;
        cnt <= cnt + 1'b1;
      end
    end
  end

  // each busy step strictly shrinks the remainder (ceil rounding, R1)
  p_rem_shrinks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !go && rem != '0 && per != '0) |=> (rem < $past(rem)));
  p_cnt_steps_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !go && rem != '0) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/pio_count_fold.sv
module pio_count_fold
  import pio_calc_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic [TW-1:0] cyc_cnt,
  input  logic [TW-1:0] act_cnt,
  input  logic [TW-1:0] set_cnt,
  input  logic [2:0]    pair_cnt,
  input  logic          shared,
  output logic [4:0]    rec_fin,
  output logic [4:0]    act_fin,
  output logic [2:0]    own_cnt,
  output logic [2:0]    merged_cnt,
  output logic [7:0]    rw_packed,
  output logic [1:0]    set_code
);
  localparam int XW = TW + 1;
  logic [XW-1:0] rec_raw;
  logic [XW-1:0] act_adj;
  logic [2:0]    pair_lim;

  always_comb begin
    rec_raw = (cyc_cnt > act_cnt) ? XW'(cyc_cnt) - XW'(act_cnt) : '0;
    act_adj = XW'(act_cnt);
    if (rec_raw > XW'(REC_CAP)) begin
      act_adj = act_adj + rec_raw - XW'(REC_CAP);
      rec_fin = 5'(REC_CAP);
    end else begin
      rec_fin = rec_raw[4:0];
    end
    act_fin = (act_adj > XW'(REC_CAP)) ? 5'(REC_CAP) : act_adj[4:0];
  end

  assign own_cnt    = lim_setup(set_cnt);
  assign pair_lim   = (pair_cnt > 3'(SET_CAP)) ? 3'(SET_CAP) : pair_cnt;
  assign merged_cnt = (shared && pair_lim > own_cnt) ? pair_lim : own_cnt;
  assign rw_packed  = {act_fin[3:0], enc_recovery(rec_fin)};
  assign set_code   = enc_setup(merged_cnt);
endmodule

// File: rtl/pio_count_calc.sv
module pio_count_calc
  import pio_calc_pkg::*;
#(
  parameter int TW         = 16,
  parameter int PW         = 8,
  parameter int DEF_PERIOD = 30,
  parameter int INTR_BIT   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [TW-1:0] cyc_ns,
  input  logic [TW-1:0] act_ns,
  input  logic [TW-1:0] setup_ns,
  input  logic [PW-1:0] period_ns,
  input  logic          sec_chan,
  input  logic          drive_sel,
  input  logic [2:0]    pair_setup,
  input  logic [7:0]    cur_setup,
  output logic          busy,
  output logic          done,
  output logic [7:0]    rw_byte,
  output logic [7:0]    setup_byte,
  output logic [1:0]    rw_idx,
  output logic [1:0]    setup_idx,
  output logic [2:0]    own_setup
);
  localparam logic [PW-1:0] DEF_P = PW'(DEF_PERIOD);

  calc_state_t   st;
  logic [TW-1:0] c_cyc, c_act, c_set;
  logic [PW-1:0] c_per;
  logic          c_sec, c_drv;
  logic [2:0]    c_pair;
  logic [7:0]    c_reg;
  logic [TW-1:0] n_cyc, n_act, n_set;
  logic          kick;
  logic [TW-1:0] div_num;
  logic          div_fin;
  logic [TW-1:0] div_q;
  logic          accept;

  logic [4:0]    rec_fin, act_fin;
  logic [2:0]    own_cnt, merged_cnt;
  logic [7:0]    rw_packed;
  logic [1:0]    set_code;
  logic [7:0]    low_keep;

  assign accept = start && (st == ST_IDLE);
  assign busy   = (st != ST_IDLE);

  always_comb begin
    case (st)
      ST_ACT:  div_num = c_act;
      ST_SET:  div_num = c_set;
      default: div_num = c_cyc;
    endcase
  end

  pio_ceil_div #(.TW(TW), .PW(PW)) u_div (
    .clk(clk), .rst_n(rst_n), .go(kick), .num(div_num), .per(c_per),
    .fin(div_fin), .quo(div_q)
  );

  pio_count_fold #(.TW(TW)) u_fold (
    .cyc_cnt(n_cyc), .act_cnt(n_act), .set_cnt(n_set),
    .pair_cnt(c_pair), .shared(c_sec),
    .rec_fin(rec_fin), .act_fin(act_fin), .own_cnt(own_cnt),
    .merged_cnt(merged_cnt), .rw_packed(rw_packed), .set_code(set_code)
  );

  always_comb begin
    low_keep = {2'b00, c_reg[5:0]};
    if (c_sec) low_keep[INTR_BIT] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      kick <= 1'b0;
      done <= 1'b0;
      c_cyc <= '0; c_act <= '0; c_set <= '0; c_per <= DEF_P;
      c_sec <= 1'b0; c_drv <= 1'b0; c_pair <= '0; c_reg <= '0;
      n_cyc <= '0; n_act <= '0; n_set <= '0;
      rw_byte <= '0; setup_byte <= '0; rw_idx <= '0; setup_idx <= '0;
      own_setup <= '0;
    end else begin
      kick <= 1'b0;
      done <= 1'b0;
      case (st)
        ST_IDLE: if (accept) begin
          c_cyc  <= cyc_ns;
          c_act  <= act_ns;
          c_set  <= setup_ns;
          c_per  <= (period_ns == '0) ? DEF_P : period_ns;
          c_sec  <= sec_chan;
          c_drv  <= drive_sel;
          c_pair <= pair_setup;
          c_reg  <= cur_setup;
          kick   <= 1'b1;
          st     <= ST_CYC;
        end
        ST_CYC: if (div_fin && !kick) begin
          n_cyc <= div_q; kick <= 1'b1; st <= ST_ACT;
        end
        ST_ACT: if (div_fin && !kick) begin
          n_act <= div_q; kick <= 1'b1; st <= ST_SET;
        end
        ST_SET: if (div_fin && !kick) begin
          n_set <= div_q; st <= ST_PACK;
        end
        default: begin
          rw_byte    <= rw_packed;
          setup_byte <= {set_code, low_keep[5:0]};
          rw_idx     <= {c_sec, c_drv};
          setup_idx  <= c_sec ? 2'd2 : {1'b0, c_drv};
          own_setup  <= own_cnt;
          done       <= 1'b1;
          st         <= ST_IDLE;
        end
      endcase
    end
  end

  // R2/R3: folded recovery never above the cap
  p_rec_capped_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PACK) |-> (rec_fin <= 5'd16));
  // R4: active limited after the fold
  p_act_capped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PACK) |-> (act_fin <= 5'd16));
  // R7: merged setup is never faster than the drive's own
  p_merge_slowest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PACK) |-> (merged_cnt >= own_cnt && merged_cnt <= 3'd5));
  // R8: written-back byte never acknowledges the secondary interrupt
  p_intr_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rw_idx[1]) |-> !setup_byte[INTR_BIT]);
  // R10: done is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10: a start while busy does not restart the sequence
  p_busy_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && st != ST_PACK) |=> busy);
  // R10: outputs are stable between done pulses
  p_out_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !$past(st == ST_PACK)) |-> $stable(rw_byte) && $stable(setup_byte));
endmodule

// File: tb/sim_pio_count_calc.sv
module sim_pio_count_calc;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] cyc_ns = '0, act_ns = '0, setup_ns = '0;
  logic [7:0]  period_ns = '0;
  logic        sec_chan = 1'b0, drive_sel = 1'b0;
  logic [2:0]  pair_setup = '0;
  logic [7:0]  cur_setup = '0;
  logic        busy, done;
  logic [7:0]  rw_byte, setup_byte;
  logic [1:0]  rw_idx, setup_idx;
  logic [2:0]  own_setup;

  int n_chk = 0;
  int n_bad = 0;
  int cyc_count = 0;
  bit timed_out = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  pio_count_calc u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cyc_ns(cyc_ns), .act_ns(act_ns),
    .setup_ns(setup_ns), .period_ns(period_ns), .sec_chan(sec_chan),
    .drive_sel(drive_sel), .pair_setup(pair_setup), .cur_setup(cur_setup),
    .busy(busy), .done(done), .rw_byte(rw_byte), .setup_byte(setup_byte),
    .rw_idx(rw_idx), .setup_idx(setup_idx), .own_setup(own_setup)
  );

  always @(posedge clk) cyc_count <= cyc_count + 1;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ceil_clk(input int t, input int p);
    return (t + p - 1) / p;
  endfunction

  function automatic int rec_code(input int r);
    if (r < 2) return 15;
    if (r == 16) return 0;
    return r - 1;
  endfunction

  function automatic int set_code(input int s);
    int tbl[6] = '{1, 1, 1, 2, 0, 3};
    return tbl[s];
  endfunction

  task automatic wait_done();
    do @(negedge clk); while (!done && cyc_count < 180000);
    if (!done) timed_out = 1'b1;
  endtask

  task automatic run_one(input int cy, input int ac, input int su, input int pr,
                         input bit sc, input bit dv, input int pa, input int rg);
    int p, cc, ca, cs, rec, own, pl, mg, exp_rw, exp_su;
    @(negedge clk);
    cyc_ns = 16'(cy); act_ns = 16'(ac); setup_ns = 16'(su);
    period_ns = 8'(pr); sec_chan = sc; drive_sel = dv;
    pair_setup = 3'(pa); cur_setup = 8'(rg);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    if (timed_out) return;
    p  = (pr == 0) ? 30 : pr;
    cc = ceil_clk(cy, p); ca = ceil_clk(ac, p); cs = ceil_clk(su, p);
    rec = (cc > ca) ? cc - ca : 0;
    if (rec > 16) begin ca = ca + rec - 16; rec = 16; end
    if (ca > 16) ca = 16;
    own = (cs > 5) ? 5 : cs;
    pl  = (pa > 5) ? 5 : pa;
    mg  = (sc && pl > own) ? pl : own;
    exp_rw = ((ca % 16) * 16) + rec_code(rec);
    exp_su = set_code(mg) * 64 + (rg % 64);
    if (sc) exp_su = exp_su & ~4;
    chk("R1/R2/R3/R4/R5 rw_byte", int'(rw_byte), exp_rw);
    chk("R6/R7 setup_byte[7:6]", int'(setup_byte[7:6]), exp_su / 64);
    chk("R8 setup_byte[5:0]", int'(setup_byte[5:0]), exp_su % 64);
    chk("R7 own_setup", int'(own_setup), own);
    chk("R9 rw_idx", int'(rw_idx), sc * 2 + dv);
    chk("R9 setup_idx", int'(setup_idx), sc ? 2 : dv);
    chk("R10 busy low with done", int'(busy), 0);
    @(negedge clk);
    chk("R10 done one cycle", int'(done), 0);
  endtask

  initial begin
    int prs[4] = '{0, 15, 30, 50};
    int cys[5] = '{0, 70, 120, 600, 900};
    int acs[6] = '{0, 70, 165, 290, 480, 600};
    int sus[5] = '{0, 25, 70, 120, 200};
    int n;
    repeat (3) @(negedge clk);
    chk("R11 done reset", int'(done), 0);
    chk("R11 busy reset", int'(busy), 0);
    chk("R11 rw_byte reset", int'(rw_byte), 0);
    chk("R11 setup_byte reset", int'(setup_byte), 0);
    chk("R11 own_setup reset", int'(own_setup), 0);
    rst_n = 1'b1;
    n = 0;
    for (int a = 0; a < 4 && !timed_out; a++)
      for (int b = 0; b < 5 && !timed_out; b++)
        for (int c = 0; c < 6 && !timed_out; c++)
          for (int d = 0; d < 5 && !timed_out; d++) begin
            run_one(cys[b], acs[c], sus[d], prs[a], n[0], n[1], n % 8,
                    ((n * 37) & 8'hfb) | ((n[2]) ? 4 : 0));
            n++;
          end
    // R10: start during busy is ignored, first request's result stands
    if (!timed_out) begin
      @(negedge clk);
      cyc_ns = 16'd600; act_ns = 16'd165; setup_ns = 16'd70; period_ns = 8'd30;
      sec_chan = 1'b0; drive_sel = 1'b1; pair_setup = 3'd0; cur_setup = 8'h2d;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      chk("R10 busy after start", int'(busy), 1);
      cyc_ns = 16'd30; act_ns = 16'd30; setup_ns = 16'd400;
      sec_chan = 1'b1; cur_setup = 8'hff; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done();
      if (!timed_out) begin
        // cycle 20, active 6, recovery 14 -> code 13; setup 3 -> field 2
        chk("R10 ignored start rw_byte", int'(rw_byte), 8'h6d);
        chk("R10 ignored start setup_byte", int'(setup_byte), 8'had);
        chk("R10 ignored start rw_idx", int'(rw_idx), 1);
      end
      @(negedge clk);
      chk("R10 no second done", int'(done), 0);
      @(negedge clk);
      chk("R10 outputs held", int'(rw_byte), 8'h6d);
    end
    if (timed_out) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<180000 cycles", cyc_count);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule